// File: doc/BRIEF.md
# Serial Boot Command and Password Gate

This block is the byte-level front end of a serial boot loader. It sits behind a serial receiver that delivers one byte at a time together with a receive-error flag, and it answers through a ready/valid transmit port. Every byte taken while the block waits for a command is decoded. The block returns an echo for a known command and an error acknowledge for a bad byte. If the byte is the RAM-transfer command, the block moves on to a password stage.

In the password stage the block takes twelve bytes and compares each one with its slot in a 96-bit reference vector. It then takes one checksum byte and raises a one-cycle completion pulse that carries the pass or fail result. A sticky error flag records any failed attempt. A mode input selects synchronous clocked operation. In that mode receive errors are not checked, and a go-ahead byte is offered before any command is taken.

Top module: `boot_gate`

## Requirements
- R1: After reset release, tx_valid, done and pwd_err are low and pass is low. With sync_mode low, rx_ready is high from the second cycle after release.
- R2: With sync_mode high during reset, the first response is 0x30. rx_ready stays low until that byte has been taken with tx_ready.
- R3: The valid command set is {0x10, 0x20, 0x30, 0x40, 0x50, 0x60}. A valid command taken without an effective receive error is echoed unchanged.
- R4: A command byte outside the set returns {P, 0x1}, where P is the upper nibble of the command byte taken before it. The block then waits for a command again.
- R5: With sync_mode low, a command byte taken with rx_err high returns {P, 0x8} and the block waits for a command again. With sync_mode high, rx_err is ignored.
- R6: The previous-command nibble P is 0x0 after reset. It takes the upper nibble of every command byte taken, whether the byte is valid, invalid or errored.
- R7: After the echo of 0x10, the next twelve bytes are password bytes. Byte k (k = 0..11, in arrival order) must equal ref_pwd[8k+7:8k].
- R8: The thirteenth byte after 0x10 is a checksum. It must equal the two's complement of the 8-bit sum of the twelve password bytes. On the cycle after the checksum byte is taken, done is high for exactly one cycle. At that time pass is 1 only if all twelve bytes matched and the checksum was correct.
- R9: pwd_err is set by a password byte mismatch or a wrong checksum. Only reset clears it, including after a later passing attempt.
- R10: While tx_valid is high and tx_ready is low, tx_data holds steady. rx_ready is low whenever a response is pending.
- R11: After the checksum byte, the block waits for a new command. The password stage sends no response byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_mode | input | 1 | 1 = clocked I/O mode (no error check, go-ahead first); hold static outside reset |
| ref_pwd | input | 96 | Stored reference password, byte k at bits 8k+7:8k |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Receive error flag for rx_data |
| rx_ready | output | 1 | Block takes the byte on this edge when rx_valid is high |
| tx_valid | output | 1 | Response byte pending |
| tx_data | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter takes tx_data |
| done | output | 1 | One-cycle pulse at the end of a password stage |
| pass | output | 1 | Result of the stage, valid with done |
| pwd_err | output | 1 | Sticky password failure flag |

## Verification
The checker watches four things on every cycle. It confirms that a held response stays stable and that no byte is accepted while a response is pending. It confirms that the nibble register follows each command byte and that an errored command in asynchronous mode yields a 0x8 acknowledge carrying the earlier nibble. It also confirms that the completion pulse lasts one cycle and that the error flag never drops and agrees with a failing result. Other behaviours depend on a whole sequence of bytes, so only the bench scenarios can show them. These are the order of the go-ahead byte, the compare order of the password bytes against the reference slots, the checksum arithmetic, and the return to command wait after a stage.

// File: rtl/boot_gate_pkg.sv
// Shared codes, widths and phase type for the serial boot command gate.
package boot_gate_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_CMDS   = 6;
    // Valid command codes, entry i at bits 8i+7:8i.
    localparam logic [NUM_CMDS*BYTE_W-1:0] CMD_TABLE =
        {8'h60, 8'h50, 8'h40, 8'h30, 8'h20, 8'h10};
    localparam logic [7:0] CMD_RAM_XFER = 8'h10;
    localparam logic [7:0] GO_AHEAD     = 8'h30;
    localparam logic [3:0] NIB_BAD_CMD  = 4'h1;
    localparam logic [3:0] NIB_RX_ERR   = 4'h8;

    typedef enum logic [1:0] {
        PH_INIT = 2'd0,
        PH_CMD  = 2'd1,
        PH_PWD  = 2'd2,
        PH_CKS  = 2'd3
    } phase_t;
endpackage

// File: rtl/bg_cmd_decode.sv
// Command decoder: flags whether a byte is one of the table's command codes.
// Assumes the table is packed with entry i at bits W*i+W-1:W*i.
module bg_cmd_decode #(
    parameter int W     = 8,
    parameter int COUNT = 6,
    parameter logic [COUNT*W-1:0] TABLE = '0
) (
    input  logic [W-1:0] code,
    output logic         is_valid
);
    logic [COUNT-1:0] hit;

    // One comparator per table entry.
    for (genvar i = 0; i < COUNT; i++) begin : g_cmp
        assign hit[i] = (code == TABLE[i*W +: W]);
    end

    // Any entry matching makes the code valid.
    assign is_valid = |hit;
endmodule

// File: rtl/bg_pwd_check.sv
// Password checker: counts incoming password bytes and keeps their running
// 8-bit sum and a mismatch flag against the reference slots.
// Assumes clear and byte_en never occur in the same cycle.
module bg_pwd_check #(
    parameter int W       = 8,
    parameter int N_BYTES = 12,
    localparam int IDX_W  = $clog2(N_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               byte_en,
    input  logic [W-1:0]       byte_in,
    input  logic [N_BYTES*W-1:0] ref_vec,
    output logic               byte_bad,
    output logic               last_byte,
    output logic               any_bad,
    output logic [W-1:0]       sum
);
    logic [W-1:0]     ref_arr [N_BYTES];
    logic [IDX_W-1:0] idx;

    // Split the reference vector into byte slots.
    for (genvar k = 0; k < N_BYTES; k++) begin : g_slot
        assign ref_arr[k] = ref_vec[k*W +: W];
    end

    // Compare the current byte with its slot and flag the final slot.
    always_comb begin
        byte_bad  = (byte_in != ref_arr[idx]);
        last_byte = (idx == IDX_W'(N_BYTES - 1));
    end

    // Slot index, running sum and accumulated mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx    <= '0;
            sum    <= '0;
            any_bad <= 1'b0;
        end else if (byte_en) begin
            idx     <= last_byte ? '0 : idx + 1'b1;
            sum     <= sum + byte_in;
            any_bad <= any_bad | byte_bad;
        end
    end
endmodule

// File: rtl/bg_tx_hold.sv
// Response holder: keeps one response byte on the transmit port until the
// transmitter takes it. Assumes load is only raised while no byte is pending.
module bg_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data
);
    // Capture on load, release on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (load) begin
            tx_valid <= 1'b1;
            tx_data  <= load_data;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/boot_gate.sv
// Serial boot command and password gate. It decodes command bytes and answers
// each one, then runs the RAM-transfer password and checksum stage.
// Assumes sync_mode changes only while rst_n is low.
module boot_gate
    import boot_gate_pkg::*;
#(
    parameter int N_PWD = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_mode,
    input  logic [N_PWD*8-1:0]    ref_pwd,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_data,
    input  logic                  rx_err,
    output logic                  rx_ready,
    output logic                  tx_valid,
    output logic [7:0]            tx_data,
    input  logic                  tx_ready,
    output logic                  done,
    output logic                  pass,
    output logic                  pwd_err
);
    phase_t     phase;
    logic       rx_fire, cmd_fire, pwd_fire, cks_fire;
    logic       err_take, cmd_ok;
    logic [3:0] prev_hi;
    logic       tx_load;
    logic [7:0] tx_byte;
    logic       byte_bad, last_byte, any_bad;
    logic [7:0] pw_sum, cks_total;
    logic       cks_ok;

    bg_cmd_decode #(.W(BYTE_W), .COUNT(NUM_CMDS), .TABLE(CMD_TABLE)) dec_i (
        .code(rx_data), .is_valid(cmd_ok)
    );

    bg_pwd_check #(.W(BYTE_W), .N_BYTES(N_PWD)) pwd_i (
        .clk(clk), .rst_n(rst_n), .clear(cmd_fire), .byte_en(pwd_fire),
        .byte_in(rx_data), .ref_vec(ref_pwd), .byte_bad(byte_bad),
        .last_byte(last_byte), .any_bad(any_bad), .sum(pw_sum)
    );

    bg_tx_hold #(.W(BYTE_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(tx_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
    );

    // Accept strobes per phase; no byte is taken while a response is pending.
    always_comb begin
        rx_ready  = (phase != PH_INIT) && !tx_valid;
        rx_fire   = rx_valid && rx_ready;
        cmd_fire  = rx_fire && (phase == PH_CMD);
        pwd_fire  = rx_fire && (phase == PH_PWD);
        cks_fire  = rx_fire && (phase == PH_CKS);
        err_take  = rx_err && !sync_mode;
        cks_total = pw_sum + rx_data;
        cks_ok    = (cks_total == 8'h00);
    end

    // Select the response byte: go-ahead, error acknowledge or echo.
    always_comb begin
        tx_load = cmd_fire || ((phase == PH_INIT) && sync_mode);
        if (phase == PH_INIT)  tx_byte = GO_AHEAD;
        else if (err_take)     tx_byte = {prev_hi, NIB_RX_ERR};
        else if (cmd_ok)       tx_byte = rx_data;
        else                   tx_byte = {prev_hi, NIB_BAD_CMD};
    end

    // Phase sequencing through command, password and checksum stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_INIT;
        end else begin
            unique case (phase)
                PH_INIT: phase <= PH_CMD;
                PH_CMD:  if (cmd_fire && !err_take && rx_data == CMD_RAM_XFER)
                             phase <= PH_PWD;
                PH_PWD:  if (pwd_fire && last_byte) phase <= PH_CKS;
                PH_CKS:  if (cks_fire) phase <= PH_CMD;
                default: phase <= PH_CMD;
            endcase
        end
    end

    // Track the upper nibble of every command byte taken.
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_hi <= 4'h0;
        else if (cmd_fire) prev_hi <= rx_data[7:4];
    end

    // Completion pulse, result and sticky failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            pass    <= 1'b0;
            pwd_err <= 1'b0;
        end else begin
            done <= cks_fire;
            if (cks_fire) pass <= !any_bad && cks_ok;
            if ((pwd_fire && byte_bad) || (cks_fire && !cks_ok))
                pwd_err <= 1'b1;
        end
    end
endmodule

// File: rtl/boot_gate_chk.sv
// Assertion checker for boot_gate, attached by bind below.
module boot_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_mode,
    input logic       rx_err,
    input logic [7:0] rx_data,
    input logic       cmd_fire,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       done,
    input logic       pass,
    input logic       pwd_err,
    input logic [3:0] prev_hi
);
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    a_r10_no_rx_pending: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    a_r6_nibble_follow: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> (prev_hi == $past(rx_data[7:4])));

    a_r5_err_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && rx_err && !sync_mode) |=>
            (tx_valid && tx_data[3:0] == 4'h8 && tx_data[7:4] == $past(prev_hi)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pwd_err |=> pwd_err);

    a_r9_fail_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> pwd_err);
endmodule

bind boot_gate boot_gate_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .rx_err(rx_err),
    .rx_data(rx_data), .cmd_fire(cmd_fire), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .done(done), .pass(pass), .pwd_err(pwd_err), .prev_hi(prev_hi)
);

// File: tb/boot_gate_tb_top.sv
// Self-checking bench for boot_gate: command table walk, then directed tests.
module boot_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_mode = 1'b0;
    logic [95:0] ref_pwd;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_err = 1'b0;
    logic        rx_ready, tx_valid, done, pass, pwd_err;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    int          n_run = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    boot_gate dut_i (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .ref_pwd(ref_pwd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .done(done), .pass(pass), .pwd_err(pwd_err)
    );

    // Command vectors: {rx_err, command byte, expected acknowledge}.
    localparam int NV = 11;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'h77, 8'h01},   // R4 first invalid, P = 0 after reset (R6)
        {1'b0, 8'h20, 8'h20},   // R3
        {1'b0, 8'h35, 8'h21},   // R4
        {1'b0, 8'h40, 8'h40},   // R3
        {1'b1, 8'h50, 8'h48},   // R5
        {1'b0, 8'hA7, 8'h51},   // R6 errored byte updated P
        {1'b0, 8'h60, 8'h60},   // R3
        {1'b0, 8'h00, 8'h61},   // R4
        {1'b1, 8'h00, 8'h08},   // R5
        {1'b0, 8'h30, 8'h30},   // R3
        {1'b0, 8'hFF, 8'h31}    // R4
    };

    function automatic logic [7:0] refb(input int k);
        return 8'(8'h11 * k + 8'h03);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic sm);
        @(negedge clk);
        rst_n = 1'b0; sync_mode = sm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic e);
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_err = e;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0; rx_err = 1'b0;
    endtask

    task automatic take_tx(input logic [7:0] exp, input string req);
        while (!tx_valid) @(negedge clk);
        check(req, tx_data, exp);
        tx_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    // One RAM-transfer stage; bad_idx < 0 means all bytes correct.
    task automatic run_pwd(input int bad_idx, input logic [7:0] cks_delta,
                           input logic exp_pass, input logic exp_err, input string req);
        logic [7:0] s;
        s = 8'h00;
        send_byte(8'h10, 1'b0);
        take_tx(8'h10, "R3 ram echo");
        for (int k = 0; k < 12; k++) begin
            logic [7:0] b;
            b = refb(k) ^ ((k == bad_idx) ? 8'h01 : 8'h00);
            s = s + b;
            send_byte(b, 1'b0);
        end
        send_byte(8'(-s) + cks_delta, 1'b0);
        check({req, " done"}, done, 1'b1);
        check({req, " pass"}, pass, exp_pass);
        check("R9 pwd_err", pwd_err, exp_err);
        check("R11 no tx", tx_valid, 1'b0);
        @(negedge clk);
        check("R8 done width", done, 1'b0);
    endtask

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 12; k++) ref_pwd[k*8 +: 8] = refb(k);

        // R1 reset state
        do_reset(1'b0);
        @(negedge clk);
        check("R1 tx_valid", tx_valid, 1'b0);
        check("R1 done", done, 1'b0);
        check("R1 pwd_err", pwd_err, 1'b0);
        check("R1 pass", pass, 1'b0);
        @(negedge clk);
        check("R1 rx_ready", rx_ready, 1'b1);

        // Command table walk
        for (int i = 0; i < NV; i++) begin
            send_byte(VEC[i][15:8], VEC[i][16]);
            take_tx(VEC[i][7:0], "R3/R4/R5 table");
        end

        // R10 hold while tx_ready low
        send_byte(8'h20, 1'b0);
        for (int c = 0; c < 3; c++) begin
            check("R10 held data", tx_data, 8'h20);
            check("R10 rx blocked", rx_ready, 1'b0);
            @(negedge clk);
        end
        take_tx(8'h20, "R10 release");

        // R7 R8 correct password, then R11 return and R6 nibble from 0x10
        run_pwd(-1, 8'h00, 1'b1, 1'b0, "R7 R8 good");
        send_byte(8'h99, 1'b0);
        take_tx(8'h11, "R11 R6 after stage");

        // R7 mismatch in last slot, then R9 stays set after good attempt
        run_pwd(11, 8'h00, 1'b0, 1'b1, "R7 bad slot11");
        run_pwd(-1, 8'h00, 1'b1, 1'b1, "R9 sticky");

        // R8 bad checksum with correct bytes
        do_reset(1'b0);
        run_pwd(-1, 8'h01, 1'b0, 1'b1, "R8 bad cks");

        // R7 mismatch in first slot
        do_reset(1'b0);
        run_pwd(0, 8'h00, 1'b0, 1'b1, "R7 bad slot0");

        // R2 go-ahead in sync mode; R5 error ignored there
        do_reset(1'b1);
        @(negedge clk);
        check("R2 rx blocked", rx_ready, 1'b0);
        while (!tx_valid) @(negedge clk);
        check("R2 rx blocked pending", rx_ready, 1'b0);
        take_tx(8'h30, "R2 go-ahead");
        send_byte(8'h50, 1'b1);
        take_tx(8'h50, "R5 sync ignores err");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule